// File: doc/BRIEF.md
# Manchester Word Transmitter with Fail-Safe and Loopback Monitors

This block turns 16-bit words into a self-clocking serial stream for a dual-redundant bus. Each accepted word goes out as a three-bit-time sync, the sixteen data bits (most significant first) and an odd parity bit. The sync shape marks the word as a command/status word or a data word. A single encoder drives both bus outputs, and each output is passed only while its own enable is high. Words offered back to back go out with no idle gap between them.

Two monitors sit beside the encoder. A fail-safe timer counts continuous transmit time. Once the permitted number of bit times has been used, it silences the output and latches a timeout flag that only reset clears. A loopback checker keeps the word, type and parity of the last word sent. It compares them with the word that the bus receiver hands back, and it pulses a failure flag on a mismatch or when no word comes back within a fixed window.

The serializer state machine has four states: `S_IDLE`, `S_SYNC`, `S_DATA` and `S_PAR`. Its transitions are:
- start: `S_IDLE`→`S_SYNC` on an accepted word.
- sync done: `S_SYNC`→`S_DATA` after six half-bits.
- data done: `S_DATA`→`S_PAR` after thirty-two half-bits.
- chain: `S_PAR`→`S_SYNC` when a new word is accepted in the last cycle.
- finish: `S_PAR`→`S_IDLE` when no new word is accepted in the last cycle.
- abort: any state→`S_IDLE` on fail-safe expiry.

The fail-safe machine has two states: `F_ARMED` and `F_TRIPPED`. Its one transition, trip, goes from `F_ARMED` to `F_TRIPPED` and is irreversible.

The loopback machine has two states: `L_IDLE` and `L_WAIT`. Its transitions are:
- arm: `L_IDLE`→`L_WAIT` on word completion.
- re-arm: `L_WAIT`→`L_WAIT` on another completion.
- resolve: `L_WAIT`→`L_IDLE` when a word is received or the window expires.

Top module: `manch_word_tx`

## Requirements
- R1: `in_ready` is high while the serializer is idle or in the final cycle of a word, and the fail-safe has not tripped. A word is taken when `in_valid` and `in_ready` are both high at a clock edge. `in_ready` is low during the rest of a word.
- R2: The sync occupies six half-bits. For a command/status word (`in_is_cmd`=1) it is three half-bits high then three low. For a data word (`in_is_cmd`=0) it is three low then three high.
- R3: The data bits follow the sync, bit 15 first. A 1 is sent as a high half-bit then a low half-bit, and a 0 as low then high.
- R4: The last bit cell carries odd parity over the 16 data bits, so the data plus parity hold an odd number of ones. It is encoded as in R3.
- R5: A word lasts 40 half-bits of `HALF_CYC` clocks each. `tx_busy` is high from the cycle after acceptance for exactly that long. Two words accepted back to back keep `tx_busy` high for twice that length with no gap.
- R6: `bus_a` carries the encoded line only while `en_a` is high, and `bus_b` only while `en_b` is high. Both buses are low whenever `tx_busy` is low.
- R7: After `LIMIT_BITS` bit times of continuous transmission, the output goes idle at once: `tx_busy` falls and both buses go low. `timeout` then stays high and `in_ready` stays low until reset.
- R8: A returned word whose data, type and parity all match the last word sent produces no `loop_fail` pulse.
- R9: A returned word that differs in data, type or parity raises `loop_fail` for one cycle, in the cycle after the one where `rx_valid` is high.
- R10: If no word returns within `LOOP_WAIT` cycles after a word's last cycle, `loop_fail` pulses in the (`LOOP_WAIT`+1)th cycle after `tx_busy` falls. A second completion while a check is still open also pulses `loop_fail` for the missing word.
- R11: `rx_valid` while no check is open has no effect on `loop_fail`.
- R12: After reset, `in_ready` is 1 and `tx_busy`, `bus_a`, `bus_b`, `timeout` and `loop_fail` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Word offered |
| in_ready | output | 1 | Word can be taken this cycle |
| in_data | input | 16 | Word to send |
| in_is_cmd | input | 1 | 1 = command/status sync, 0 = data sync |
| en_a | input | 1 | Enable for bus A |
| en_b | input | 1 | Enable for bus B |
| bus_a | output | 1 | Serial output, bus A |
| bus_b | output | 1 | Serial output, bus B |
| tx_busy | output | 1 | A word is being sent |
| rx_valid | input | 1 | Word received back from the bus |
| rx_data | input | 16 | Received data bits |
| rx_is_cmd | input | 1 | Received sync type |
| rx_parity | input | 1 | Received parity bit |
| timeout | output | 1 | Fail-safe tripped (sticky) |
| loop_fail | output | 1 | One-cycle loopback failure pulse |

## Verification
With a half-bit of two clocks, the line for a word appears on the buses from the cycle after acceptance. It lasts 80 cycles, with the first half of each bit cell at even offsets. The bench monitor samples every busy cycle at the falling edge and decodes each 80-cycle run against the word popped from the queue. A mismatching returned word shows `loop_fail` at the falling edge one cycle after `rx_valid` was driven, and it is checked there and again one cycle later for its return to 0. A missing word is checked by counting idle cycles since `tx_busy` fell: the pulse must land on cycle `LOOP_WAIT`+1. The fail-safe is checked by measuring the busy run, which must equal `LIMIT_BITS`×2×`HALF_CYC` cycles.

// File: rtl/mtx_pkg.sv
package mtx_pkg;

    localparam int WORD_W  = 16;
    localparam int SYNC_HB = 6;
    localparam int HALVES  = SYNC_HB + 2 * WORD_W + 2;

    typedef enum logic [1:0] {S_IDLE, S_SYNC, S_DATA, S_PAR} tx_state_e;
    typedef enum logic {F_ARMED, F_TRIPPED} fs_state_e;
    typedef enum logic {L_IDLE, L_WAIT} lb_state_e;

    function automatic logic [HALVES-1:0] build_halves(input logic [WORD_W-1:0] d,
                                                       input logic cmd);
        logic [HALVES-1:0] r;
        logic par;
        par = ~^d;
        r = '0;
        r[HALVES-1 -: SYNC_HB] = cmd ? 6'b111000 : 6'b000111;
        for (int i = 0; i < WORD_W; i++) begin
            r[HALVES-1-SYNC_HB-2*i -: 2] = d[WORD_W-1-i] ? 2'b10 : 2'b01;
        end
        r[1:0] = par ? 2'b10 : 2'b01;
        return r;
    endfunction

endpackage

// File: rtl/mtx_serializer.sv
module mtx_serializer
    import mtx_pkg::*;
#(
    parameter int HALF_CYC = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_data,
    input  logic              in_is_cmd,
    input  logic              abort,
    output logic              line,
    output logic              busy,
    output logic              word_done,
    output logic [WORD_W-1:0] done_data,
    output logic              done_cmd
);
    localparam int IDX_W    = $clog2(HALVES + 1);
    localparam int CYC_W    = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam int SYNC_END = SYNC_HB - 1;
    localparam int DATA_END = SYNC_HB + 2 * WORD_W - 1;
    localparam int LAST_HB  = HALVES - 1;

    tx_state_e         state_q, state_d;
    logic [IDX_W-1:0]  idx_q;
    logic [CYC_W-1:0]  cyc_q;
    logic [HALVES-1:0] pat_q;
    logic [WORD_W-1:0] data_q;
    logic              cmd_q;
    logic              half_end, last, accept;

    always_comb begin
        half_end = (cyc_q == CYC_W'(HALF_CYC - 1));
        last     = (state_q == S_PAR) && (idx_q == IDX_W'(LAST_HB)) && half_end;
        in_ready = !abort && ((state_q == S_IDLE) || last);
        accept   = in_valid && in_ready;
        state_d  = state_q;
        unique case (state_q)
            S_IDLE: if (accept) state_d = S_SYNC;
            S_SYNC: if (half_end && idx_q == IDX_W'(SYNC_END)) state_d = S_DATA;
            S_DATA: if (half_end && idx_q == IDX_W'(DATA_END)) state_d = S_PAR;
            S_PAR:  if (last) state_d = accept ? S_SYNC : S_IDLE;
            default: state_d = S_IDLE;
        endcase
        if (abort) state_d = S_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= '0;
            cyc_q  <= '0;
            pat_q  <= '0;
            data_q <= '0;
            cmd_q  <= 1'b0;
        end else if (accept) begin
            idx_q  <= '0;
            cyc_q  <= '0;
            pat_q  <= build_halves(in_data, in_is_cmd);
            data_q <= in_data;
            cmd_q  <= in_is_cmd;
        end else if (state_q != S_IDLE) begin
            if (half_end) begin
                cyc_q <= '0;
                idx_q <= idx_q + 1'b1;
                pat_q <= pat_q << 1;
            end else begin
                cyc_q <= cyc_q + 1'b1;
            end
        end
    end

    always_comb begin
        busy      = (state_q != S_IDLE);
        line      = busy && pat_q[HALVES-1];
        word_done = last && !abort;
        done_data = data_q;
        done_cmd  = cmd_q;
    end

    p_idx_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE) |-> (idx_q < IDX_W'(HALVES)));

    p_sync_flip_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_SYNC && idx_q == IDX_W'(3) && cyc_q == '0) |-> (line != $past(line)));

    p_mid_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DATA && idx_q[0] && cyc_q == '0) |-> (line != $past(line)));

endmodule

// File: rtl/mtx_failsafe.sv
module mtx_failsafe
    import mtx_pkg::*;
#(
    parameter int LIMIT_CYC = 2500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    output logic expire,
    output logic timeout
);
    localparam int CNT_W = $clog2(LIMIT_CYC + 1);

    fs_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        expire  = (state_q == F_ARMED) && busy && (cnt_q == CNT_W'(LIMIT_CYC - 1));
        state_d = state_q;
        unique case (state_q)
            F_ARMED:   if (expire) state_d = F_TRIPPED;
            F_TRIPPED: state_d = F_TRIPPED;
            default:   state_d = F_ARMED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= F_ARMED;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt_q <= '0;
        else if (busy) cnt_q <= cnt_q + 1'b1;
        else           cnt_q <= '0;
    end

    always_comb timeout = (state_q == F_TRIPPED);

    p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == F_ARMED) |-> (cnt_q < CNT_W'(LIMIT_CYC)));

endmodule

// File: rtl/mtx_loopcheck.sv
module mtx_loopcheck
    import mtx_pkg::*;
#(
    parameter int LOOP_WAIT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_done,
    input  logic [WORD_W-1:0] done_data,
    input  logic              done_cmd,
    input  logic              rx_valid,
    input  logic [WORD_W-1:0] rx_data,
    input  logic              rx_is_cmd,
    input  logic              rx_parity,
    output logic              loop_fail
);
    localparam int CNT_W = $clog2(LOOP_WAIT + 1);

    lb_state_e         state_q, state_d;
    logic [WORD_W-1:0] exp_data;
    logic              exp_cmd;
    logic [CNT_W-1:0]  cnt_q;
    logic              fail_q, fail_d, mismatch, window_end;

    always_comb begin
        mismatch   = (rx_data != exp_data) || (rx_is_cmd != exp_cmd) || (rx_parity != ~^exp_data);
        window_end = (cnt_q == CNT_W'(LOOP_WAIT - 1));
        fail_d     = 1'b0;
        state_d    = state_q;
        unique case (state_q)
            L_IDLE: if (word_done) state_d = L_WAIT;
            L_WAIT: begin
                fail_d = rx_valid ? mismatch : (window_end || word_done);
                if (word_done)                    state_d = L_WAIT;
                else if (rx_valid || window_end)  state_d = L_IDLE;
            end
            default: state_d = L_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= L_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exp_data <= '0;
            exp_cmd  <= 1'b0;
            cnt_q    <= '0;
            fail_q   <= 1'b0;
        end else begin
            fail_q <= fail_d;
            if (word_done) begin
                exp_data <= done_data;
                exp_cmd  <= done_cmd;
                cnt_q    <= '0;
            end else if (state_q == L_WAIT) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    always_comb loop_fail = fail_q;

    p_window_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == L_WAIT) |-> (cnt_q < CNT_W'(LOOP_WAIT)));

endmodule

// File: rtl/manch_word_tx.sv
module manch_word_tx
    import mtx_pkg::*;
#(
    parameter int HALF_CYC   = 25,
    parameter int LIMIT_BITS = 50,
    parameter int LOOP_WAIT  = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [15:0] in_data,
    input  logic        in_is_cmd,
    input  logic        en_a,
    input  logic        en_b,
    output logic        bus_a,
    output logic        bus_b,
    output logic        tx_busy,
    input  logic        rx_valid,
    input  logic [15:0] rx_data,
    input  logic        rx_is_cmd,
    input  logic        rx_parity,
    output logic        timeout,
    output logic        loop_fail
);
    localparam int LIMIT_CYC = LIMIT_BITS * 2 * HALF_CYC;

    logic              line, busy, expire, tripped, abort, word_done, done_cmd;
    logic [WORD_W-1:0] done_data;

    always_comb abort = expire || tripped;

    mtx_serializer #(.HALF_CYC(HALF_CYC)) u_ser (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_is_cmd(in_is_cmd), .abort(abort), .line(line),
        .busy(busy), .word_done(word_done), .done_data(done_data), .done_cmd(done_cmd)
    );

    mtx_failsafe #(.LIMIT_CYC(LIMIT_CYC)) u_fs (
        .clk(clk), .rst_n(rst_n), .busy(busy), .expire(expire), .timeout(tripped)
    );

    mtx_loopcheck #(.LOOP_WAIT(LOOP_WAIT)) u_lb (
        .clk(clk), .rst_n(rst_n), .word_done(word_done), .done_data(done_data),
        .done_cmd(done_cmd), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_is_cmd(rx_is_cmd), .rx_parity(rx_parity), .loop_fail(loop_fail)
    );

    always_comb begin
        bus_a   = line && en_a;
        bus_b   = line && en_b;
        tx_busy = busy;
        timeout = tripped;
    end

    p_timeout_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |=> timeout);

    p_halt_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> (!in_ready && !tx_busy));

    p_quiet_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> (!bus_a && !bus_b));

endmodule

// File: tb/manch_word_tx_test.sv
module manch_word_tx_test;
    localparam int HC = 2, LB = 50, LW = 8;
    localparam int WCYC = 40 * HC;

    logic clk = 1'b0, rst_n = 1'b0;
    logic in_valid = 1'b0, in_is_cmd = 1'b0, en_a = 1'b1, en_b = 1'b1;
    logic [15:0] in_data = '0, rx_data = '0;
    logic rx_valid = 1'b0, rx_is_cmd = 1'b0, rx_parity = 1'b0;
    logic in_ready, bus_a, bus_b, tx_busy, timeout, loop_fail;

    manch_word_tx #(.HALF_CYC(HC), .LIMIT_BITS(LB), .LOOP_WAIT(LW)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_is_cmd(in_is_cmd), .en_a(en_a), .en_b(en_b),
        .bus_a(bus_a), .bus_b(bus_b), .tx_busy(tx_busy), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_is_cmd(rx_is_cmd), .rx_parity(rx_parity),
        .timeout(timeout), .loop_fail(loop_fail)
    );

    always #10 clk = ~clk;

    int checks = 0, failures = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    typedef struct { logic [15:0] d; logic c; } item_t;
    item_t q[$];

    // monitor state
    logic samp[WCYC];
    int sidx = 0, run = 0, last_run = 0, ahigh = 0, bhigh = 0, diff = 0;
    int idle_cyc = 0, fail_pulses = 0, last_fail_idle = 0, trunc = 0;
    bit skip_cmp = 0;

    function automatic logic [39:0] exp_halves(input logic [15:0] d, input logic c);
        logic [39:0] r;
        r[39:34] = c ? 6'b111000 : 6'b000111;
        for (int k = 0; k < 16; k++) r[33-2*k -: 2] = d[15-k] ? 2'b10 : 2'b01;
        r[1:0] = (~^d) ? 2'b10 : 2'b01;
        return r;
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_busy) begin
                idle_cyc = 0;
                run++;
                samp[sidx] = bus_a | bus_b;
                if (bus_a) ahigh++;
                if (bus_b) bhigh++;
                if (bus_a != bus_b) diff++;
                sidx++;
                if (sidx == WCYC) begin
                    logic [39:0] g, e;
                    item_t it;
                    sidx = 0;
                    if (q.size() == 0) chk(0, "R5", "unexpected word", 0, 1);
                    else begin
                        it = q.pop_front();
                        if (!skip_cmp) begin
                            for (int h = 0; h < 40; h++) g[39-h] = samp[h*HC];
                            e = exp_halves(it.d, it.c);
                            chk(g[39:34] == e[39:34], "R2", "sync halves", int'(g[39:34]), int'(e[39:34]));
                            chk(g[33:2] == e[33:2], "R3", "data halves", int'(g[33:2]), int'(e[33:2]));
                            chk(g[1:0] == e[1:0], "R4", "parity halves", int'(g[1:0]), int'(e[1:0]));
                        end
                    end
                end
            end else begin
                idle_cyc++;
                if (run > 0) begin last_run = run; run = 0; end
                if (sidx != 0) begin
                    trunc++;
                    sidx = 0;
                    if (q.size() > 0) void'(q.pop_front());
                end
            end
            if (loop_fail) begin fail_pulses++; last_fail_idle = idle_cyc; end
        end
    end

    task automatic do_reset();
        rst_n = 1'b0; in_valid = 1'b0; rx_valid = 1'b0;
        q.delete();
        sidx = 0; run = 0; last_run = 0; ahigh = 0; bhigh = 0; diff = 0;
        idle_cyc = 0; fail_pulses = 0; last_fail_idle = 0; trunc = 0; skip_cmp = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic send_word(input logic [15:0] d, input logic c);
        item_t it;
        it.d = d; it.c = c;
        q.push_back(it);
        in_data = d; in_is_cmd = c; in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (tx_busy) @(negedge clk);
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic clr();
        ahigh = 0; bhigh = 0; diff = 0; fail_pulses = 0;
    endtask

    task automatic rx_bad(input logic [15:0] d, input logic c, input logic p, input string what);
        rx_data = d; rx_is_cmd = c; rx_parity = p; rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
        chk(loop_fail == 1'b1, "R9", {what, " pulse"}, int'(loop_fail), 1);
        @(negedge clk);
        chk(loop_fail == 1'b0, "R9", {what, " one cycle"}, int'(loop_fail), 0);
    endtask

    initial begin
        do_reset();
        // R12 reset state
        chk(in_ready == 1'b1, "R12", "in_ready", int'(in_ready), 1);
        chk({tx_busy, bus_a, bus_b} == 3'b000, "R12", "busy/bus", int'({tx_busy, bus_a, bus_b}), 0);
        chk({timeout, loop_fail} == 2'b00, "R12", "flags", int'({timeout, loop_fail}), 0);

        // command word, matching loopback
        #1; clr();
        send_word(16'hA5C3, 1'b1);
        chk(in_ready == 1'b0 && tx_busy == 1'b1, "R1", "ready low mid-word", int'(in_ready), 0);
        wait_idle();
        rx_data = 16'hA5C3; rx_is_cmd = 1'b1; rx_parity = ~^16'hA5C3; rx_valid = 1'b1;
        @(negedge clk); rx_valid = 1'b0;
        settle(20);
        chk(fail_pulses == 0, "R8", "no fail on match", fail_pulses, 0);
        chk(diff == 0, "R6", "both buses equal", diff, 0);
        chk(last_run == WCYC, "R5", "word length", last_run, WCYC);

        // back to back data words, no loopback
        clr();
        send_word(16'h0001, 1'b0);
        send_word(16'hFFFE, 1'b0);
        wait_idle();
        settle(20);
        chk(last_run == 2 * WCYC, "R5", "back-to-back run", last_run, 2 * WCYC);
        chk(fail_pulses == 2, "R10", "two missing words", fail_pulses, 2);

        // mismatches
        send_word(16'h1234, 1'b0); wait_idle();
        rx_bad(16'h1235, 1'b0, ~^16'h1234, "data");
        settle(15);
        send_word(16'h8000, 1'b1); wait_idle();
        rx_bad(16'h8000, 1'b0, ~^16'h8000, "type");
        settle(15);
        send_word(16'h7777, 1'b0); wait_idle();
        rx_bad(16'h7777, 1'b0, ^16'h7777, "parity");
        settle(15);

        // missing word timing
        clr();
        send_word(16'h0F0F, 1'b1); wait_idle();
        settle(20);
        chk(fail_pulses == 1, "R10", "missing pulse count", fail_pulses, 1);
        chk(last_fail_idle == LW + 1, "R10", "missing pulse cycle", last_fail_idle, LW + 1);

        // R11 stray rx with no open check
        rx_data = 16'hDEAD; rx_is_cmd = 1'b0; rx_parity = 1'b0; rx_valid = 1'b1;
        @(negedge clk); rx_valid = 1'b0;
        chk(loop_fail == 1'b0, "R11", "stray rx ignored", int'(loop_fail), 0);
        settle(3);
        chk(fail_pulses == 1, "R11", "no extra pulse", fail_pulses, 1);

        // gating R6
        clr(); en_a = 1'b1; en_b = 1'b0;
        send_word(16'hC0DE, 1'b0); wait_idle(); settle(15);
        chk(bhigh == 0 && ahigh > 0, "R6", "bus_b silent", bhigh, 0);
        clr(); en_a = 1'b0; en_b = 1'b1;
        send_word(16'h3C3C, 1'b1); wait_idle(); settle(15);
        chk(ahigh == 0 && bhigh > 0, "R6", "bus_a silent", ahigh, 0);
        clr(); en_a = 1'b0; en_b = 1'b0; skip_cmp = 1;
        send_word(16'hFFFF, 1'b1); wait_idle(); settle(15);
        chk(ahigh == 0 && bhigh == 0, "R6", "both silent", ahigh + bhigh, 0);
        chk(last_run == WCYC, "R6", "word still timed", last_run, WCYC);
        skip_cmp = 0;

        // fail-safe R7
        en_a = 1'b1; en_b = 1'b1;
        do_reset();
        send_word(16'h1111, 1'b1);
        send_word(16'h2222, 1'b0);
        send_word(16'h3333, 1'b0);
        wait_idle();
        settle(5);
        chk(last_run == LB * 2 * HC, "R7", "busy run at limit", last_run, LB * 2 * HC);
        chk(timeout == 1'b1, "R7", "timeout latched", int'(timeout), 1);
        chk(trunc == 1, "R7", "third word cut", trunc, 1);
        settle(30);
        chk(timeout == 1'b1 && in_ready == 1'b0, "R7", "stays tripped", int'({timeout, in_ready}), 2);
        chk({bus_a, bus_b, tx_busy} == 3'b000, "R7", "output idle", int'({bus_a, bus_b, tx_busy}), 0);

        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; failures++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule